// File: doc/BRIEF.md
# Bridge downstream address claim decoder

This block sits on the downstream side of a bridge. For each transaction arriving from the upstream backbone, it decides whether the transaction is claimed and forwarded to the downstream port. A request carries a type (memory or I/O) and an address. The configured I/O window is given as a base page and a limit page, each at 4 KB granularity. Three control bits are held inside the block and set through a one-word write port: legacy display enable, strict 16-bit display decode, and legacy ISA carve-out. Each request yields one registered claim decision and a two-bit reason code.

The only memory range the block ever claims is the legacy display aperture. An I/O request is claimed in two cases: it falls inside the window and is not carved out by the ISA mode, or it matches one of the legacy display port ranges. A display port match may use 10-bit aliasing. When the ISA mode is on, the upper 768 bytes of each 1 KB block are removed from the forwarded window, but only for window addresses below 64 KB.

Top module: `bridge_claim_decoder`

## Requirements
- R1: After reset, the response outputs and all three control bits are zero. Until software writes the controls, display-range addresses are not claimed and window hits are never carved out.
- R2: `rsp_valid` is high exactly one cycle after `req_valid`. When no request is presented, `rsp_claim` and `rsp_reason` keep their previous values.
- R3: An I/O request with base ≤ address[ADDR_W-1:12] ≤ limit is claimed with reason WINDOW (code 1), unless R8 or R10 applies.
- R4: With display enable set, memory addresses 0xA0000 to 0xBFFFF are claimed with reason VGA (code 2). Any other memory address, and any memory address while display enable is clear, gives reason NONE with no claim.
- R5: With display enable set, I/O addresses whose bits 9:0 lie in 0x3B0–0x3BB or 0x3C0–0x3DF are claimed with reason VGA whatever the window. With display enable clear these ranges get no special treatment.
- R6: With strict 16-bit decode clear, the display I/O match uses address bits 9:0 only, so every value of the upper bits is an alias and is claimed.
- R7: With strict 16-bit decode set, a display I/O match also requires all address bits above bit 9 to be zero.
- R8: With ISA carve-out set, an in-window I/O address below 0x10000 whose bits 9:8 are not both zero is not claimed and reports reason ISA_BLOCKED (code 3). If bits 9:8 are both zero, R3 applies.
- R9: The ISA carve-out has no effect on window addresses at or above 0x10000.
- R10: A display I/O match (R5) takes priority over the ISA carve-out and over the window.
- R11: Control word layout: bit 0 is ISA carve-out, bit 1 is display enable, bit 2 is strict 16-bit decode. A write takes effect for requests from the next cycle onward. A request in the same cycle as the write still sees the old value.
- R12: An I/O request that matches neither the window nor an enabled display range gives reason NONE (code 0) with no claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 3 | Control word: bit0 ISA carve-out, bit1 display enable, bit2 strict 16-bit decode |
| req_valid | input | 1 | Request strobe |
| req_is_io | input | 1 | 1 = I/O transaction, 0 = memory transaction |
| req_addr | input | ADDR_W | Transaction address |
| io_base | input | ADDR_W-12 | I/O window base page (4 KB units) |
| io_limit | input | ADDR_W-12 | I/O window limit page (4 KB units, inclusive) |
| rsp_valid | output | 1 | Decision valid, one cycle after the request |
| rsp_claim | output | 1 | 1 = transaction is claimed and forwarded |
| rsp_reason | output | 2 | 0 NONE, 1 WINDOW, 2 VGA, 3 ISA_BLOCKED |

## Verification
The decision for a request is due on the first rising edge after the strobe, together with `rsp_valid`. The bench therefore drives each request on a falling edge and compares outputs shortly after the next rising edge, so that one request is checked per cycle. A control write is registered on its own edge, so it is first seen by a request presented one cycle later. The bench checks this by pairing a write with a same-cycle request and then repeating that request. The hold behaviour is checked one cycle after the strobe drops, while the address changes underneath.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

   typedef enum logic [1:0] {
      CLAIM_NONE      = 2'd0,
      CLAIM_WINDOW    = 2'd1,
      CLAIM_VGA       = 2'd2,
      CLAIM_ISA_BLOCK = 2'd3
   } claim_reason_e;

   // Packed so that the write port's bit layout falls out directly.
   typedef struct packed {
      logic vga16;    // bit 2
      logic vga_en;   // bit 1
      logic isa_en;   // bit 0
   } ctl_bits_t;

   localparam int CTL_W = $bits(ctl_bits_t);

endpackage

// File: rtl/bdc_ctl_reg.sv
module bdc_ctl_reg
   import bdc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   output ctl_bits_t        ctl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= ctl_bits_t'('0);
      else if (wr_en)
         ctl_q <= ctl_bits_t'(wr_data);
   end

endmodule

// File: rtl/bdc_vga_match.sv
module bdc_vga_match #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              strict16,
   output logic              mem_hit,
   output logic              io_hit
);

   localparam int NUM_IO_RANGES = 2;
   localparam int ALIAS_BITS    = 10;
   localparam int APER_LSB      = 17;
   localparam int APER_MSB      = 19;

   localparam logic [NUM_IO_RANGES-1:0][ALIAS_BITS-1:0] RANGE_LO = {10'h3C0, 10'h3B0};
   localparam logic [NUM_IO_RANGES-1:0][ALIAS_BITS-1:0] RANGE_HI = {10'h3DF, 10'h3BB};

   logic [NUM_IO_RANGES-1:0] range_hit;
   logic                     above_alias_zero;
   logic                     above_aper_zero;

   for (genvar g = 0; g < NUM_IO_RANGES; g++) begin : g_io_range
      assign range_hit[g] = (addr[ALIAS_BITS-1:0] >= RANGE_LO[g]) &&
                            (addr[ALIAS_BITS-1:0] <= RANGE_HI[g]);
   end

   assign above_alias_zero = ~|addr[ADDR_W-1:ALIAS_BITS];

   if (ADDR_W > APER_MSB + 1) begin : g_wide_mem
      assign above_aper_zero = ~|addr[ADDR_W-1:APER_MSB+1];
   end else begin : g_narrow_mem
      assign above_aper_zero = 1'b1;
   end

   // The display aperture 0xA0000..0xBFFFF is exactly bits 19:17 == 3'b101.
   assign mem_hit = above_aper_zero && (addr[APER_MSB:APER_LSB] == 3'b101);
   assign io_hit  = (|range_hit) && (!strict16 || above_alias_zero);

endmodule

// File: rtl/bdc_io_window.sv
module bdc_io_window #(
   parameter int ADDR_W        = 32,
   parameter int GRAN_BITS     = 12,
   parameter int ISA_SPAN_BITS = 16,
   localparam int IDX_W        = ADDR_W - GRAN_BITS
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [IDX_W-1:0]  base,
   input  logic [IDX_W-1:0]  limit,
   output logic              in_win,
   output logic              isa_zone
);

   localparam int BLK_BITS = 10;

   logic [IDX_W-1:0] page;
   logic             below_span;

   assign page   = addr[ADDR_W-1:GRAN_BITS];
   assign in_win = (page >= base) && (page <= limit);

   if (ADDR_W > ISA_SPAN_BITS) begin : g_span_check
      assign below_span = ~|addr[ADDR_W-1:ISA_SPAN_BITS];
   end else begin : g_span_all
      assign below_span = 1'b1;
   end

   // Offsets 0x100..0x3FF inside each 1 KB block have bits 9:8 non-zero.
   assign isa_zone = below_span && (|addr[BLK_BITS-1:BLK_BITS-2]);

   wire unused_addr_bits = ^{addr[GRAN_BITS-1:BLK_BITS], addr[BLK_BITS-3:0]};

endmodule

// File: rtl/bridge_claim_decoder.sv
module bridge_claim_decoder
   import bdc_pkg::*;
#(
   parameter int  ADDR_W        = 32,
   parameter int  GRAN_BITS     = 12,
   parameter int  ISA_SPAN_BITS = 16,
   localparam int IDX_W         = ADDR_W - GRAN_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_en,
   input  logic [2:0]        ctl_wr_data,
   input  logic              req_valid,
   input  logic              req_is_io,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [IDX_W-1:0]  io_base,
   input  logic [IDX_W-1:0]  io_limit,
   output logic              rsp_valid,
   output logic              rsp_claim,
   output logic [1:0]        rsp_reason
);

   if (ADDR_W < 20) begin : g_bad_addr_w
      $error("bridge_claim_decoder: ADDR_W must cover the display aperture (>= 20)");
   end
   if (GRAN_BITS <= 10 || GRAN_BITS >= ADDR_W) begin : g_bad_gran
      $error("bridge_claim_decoder: GRAN_BITS must lie above the 1 KB block and below ADDR_W");
   end
   if (ISA_SPAN_BITS <= 10) begin : g_bad_span
      $error("bridge_claim_decoder: ISA_SPAN_BITS must exceed the 1 KB block");
   end
   if (CTL_W != 3) begin : g_bad_ctl
      $error("bridge_claim_decoder: control word width mismatch");
   end

   ctl_bits_t     ctl_q;
   logic          vga_mem_hit;
   logic          vga_io_hit;
   logic          in_win;
   logic          isa_zone;
   logic          vga_claim;
   claim_reason_e reason_nxt;
   logic          claim_nxt;

   bdc_ctl_reg u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctl_wr_en),
      .wr_data (ctl_wr_data),
      .ctl_q   (ctl_q)
   );

   bdc_vga_match #(.ADDR_W(ADDR_W)) u_vga (
      .addr     (req_addr),
      .strict16 (ctl_q.vga16),
      .mem_hit  (vga_mem_hit),
      .io_hit   (vga_io_hit)
   );

   bdc_io_window #(
      .ADDR_W        (ADDR_W),
      .GRAN_BITS     (GRAN_BITS),
      .ISA_SPAN_BITS (ISA_SPAN_BITS)
   ) u_win (
      .addr     (req_addr),
      .base     (io_base),
      .limit    (io_limit),
      .in_win   (in_win),
      .isa_zone (isa_zone)
   );

   // Priority: display match, then window (with optional ISA carve-out).
   always_comb begin
      vga_claim = ctl_q.vga_en && (req_is_io ? vga_io_hit : vga_mem_hit);
      if (vga_claim)
         reason_nxt = CLAIM_VGA;
      else if (req_is_io && in_win)
         reason_nxt = (ctl_q.isa_en && isa_zone) ? CLAIM_ISA_BLOCK : CLAIM_WINDOW;
      else
         reason_nxt = CLAIM_NONE;
      claim_nxt = (reason_nxt == CLAIM_WINDOW) || (reason_nxt == CLAIM_VGA);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_claim  <= 1'b0;
         rsp_reason <= CLAIM_NONE;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_claim  <= claim_nxt;
            rsp_reason <= reason_nxt;
         end
      end
   end

endmodule

// File: rtl/bdc_checker.sv
module bdc_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_is_io,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_claim,
   input logic [1:0]        rsp_reason
);

   assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rsp_claim) && $stable(rsp_reason)));

   assert_mem_outside_aperture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_io && (req_addr[19:17] != 3'b101)) |=>
         (!rsp_claim && (rsp_reason == 2'd0)));

   assert_isa_block_no_claim_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_reason == 2'd3)) |-> !rsp_claim);

   assert_mem_never_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_io) |=> ((rsp_reason == 2'd0) || (rsp_reason == 2'd2)));

endmodule

bind bridge_claim_decoder bdc_checker #(.ADDR_W(ADDR_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_is_io  (req_is_io),
   .req_addr   (req_addr),
   .rsp_valid  (rsp_valid),
   .rsp_claim  (rsp_claim),
   .rsp_reason (rsp_reason)
);

// File: tb/bridge_claim_decoder_tb_top.sv
`timescale 1ns/1ps
module bridge_claim_decoder_tb_top;

   localparam int ADDR_W = 32;
   localparam int IDX_W  = ADDR_W - 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ctl_wr_en = 1'b0;
   logic [2:0]        ctl_wr_data = '0;
   logic              req_valid = 1'b0;
   logic              req_is_io = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [IDX_W-1:0]  io_base = IDX_W'(1);
   logic [IDX_W-1:0]  io_limit = IDX_W'(32'h11);
   logic              rsp_valid;
   logic              rsp_claim;
   logic [1:0]        rsp_reason;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;
   bit  s_isa = 1'b0, s_vga = 1'b0, s_v16 = 1'b0;

   always #2 clk = ~clk;

   bridge_claim_decoder dut_i (
      .clk (clk), .rst_n (rst_n), .ctl_wr_en (ctl_wr_en), .ctl_wr_data (ctl_wr_data),
      .req_valid (req_valid), .req_is_io (req_is_io), .req_addr (req_addr),
      .io_base (io_base), .io_limit (io_limit),
      .rsp_valid (rsp_valid), .rsp_claim (rsp_claim), .rsp_reason (rsp_reason)
   );

   function automatic int exp_reason(input bit io, input longint a);
      longint low = a % 1024;
      bit vr = (low >= 'h3B0 && low <= 'h3BB) || (low >= 'h3C0 && low <= 'h3DF);
      longint page = a >> 12;
      if (!io) return (s_vga && a >= 'hA0000 && a <= 'hBFFFF) ? 2 : 0;
      if (s_vga && vr && (!s_v16 || a < 1024)) return 2;
      if (page >= longint'(io_base) && page <= longint'(io_limit)) begin
         if (s_isa && a < 'h10000 && low >= 'h100) return 3;
         return 1;
      end
      return 0;
   endfunction

   function automatic string pick_tag(input bit io, input longint a, input int r);
      longint low = a % 1024;
      bit vr = (low >= 'h3B0 && low <= 'h3BB) || (low >= 'h3C0 && low <= 'h3DF);
      longint page = a >> 12;
      bit win = page >= longint'(io_base) && page <= longint'(io_limit);
      if (!io) return "R4";
      if (r == 2 && win && s_isa) return "R10";
      if (r == 2) return s_v16 ? "R7" : ((a >= 1024) ? "R6" : "R5");
      if (vr && s_vga && s_v16) return "R7";
      if (vr && !s_vga) return "R5";
      if (r == 3) return "R8";
      if (r == 1 && s_isa && a >= 'h10000) return "R9";
      if (r == 1) return "R3";
      return "R12";
   endfunction

   task automatic check(input string tag, input bit v, input bit c, input int r,
                        input bit ev, input bit ec, input int er);
      n_checks++;
      if (v !== ev || c !== ec || int'(r) != er) begin
         n_errors++;
         $display("FAIL %s: valid/claim/reason = %0b/%0b/%0d, expected %0b/%0b/%0d",
                  tag, v, c, r, ev, ec, er);
      end
   endtask

   task automatic set_ctl(input bit isa, input bit vga, input bit v16);
      @(negedge clk);
      req_valid   = 1'b0;
      ctl_wr_en   = 1'b1;
      ctl_wr_data = {v16, vga, isa};
      @(negedge clk);
      ctl_wr_en = 1'b0;
      s_isa = isa; s_vga = vga; s_v16 = v16;
   endtask

   task automatic do_req(input bit io, input longint a);
      int er;
      @(negedge clk);
      req_valid = 1'b1;
      req_is_io = io;
      req_addr  = ADDR_W'(a);
      er = exp_reason(io, a);
      @(posedge clk);
      #1;
      check(pick_tag(io, a, er), rsp_valid, rsp_claim, int'(rsp_reason),
            1'b1, (er == 1 || er == 2), er);
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      int ups[5] = '{0, 4, 'h3F, 'h40, 'h48};
      longint mems[8] = '{'h9FFFF, 'hA0000, 'hAFFF0, 'hBFFFF, 'hC0000,
                          'h100A0000, 'hB8000, 'h1300};
      bit     prev_c;
      logic [1:0] prev_r;

      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1", rsp_valid, rsp_claim, int'(rsp_reason), 1'b0, 1'b0, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: controls are zero after reset
      do_req(1'b0, 'hA0000);
      check("R1", rsp_valid, rsp_claim, int'(rsp_reason), 1'b1, 1'b0, 0);
      do_req(1'b1, 'h13C0);
      check("R1", rsp_valid, rsp_claim, int'(rsp_reason), 1'b1, 1'b1, 1);

      // R2: hold when idle
      prev_c = rsp_claim;
      prev_r = rsp_reason;
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = 'h0;
      @(posedge clk);
      #1;
      check("R2", rsp_valid, rsp_claim, int'(rsp_reason), 1'b0, prev_c, int'(prev_r));

      // R11: write is seen from the next request on
      @(negedge clk);
      ctl_wr_en   = 1'b1;
      ctl_wr_data = 3'b010;
      req_valid   = 1'b1;
      req_is_io   = 1'b0;
      req_addr    = 'hA0000;
      @(posedge clk);
      #1;
      check("R11", rsp_valid, rsp_claim, int'(rsp_reason), 1'b1, 1'b0, 0);
      @(negedge clk);
      ctl_wr_en = 1'b0;
      @(posedge clk);
      #1;
      check("R11", rsp_valid, rsp_claim, int'(rsp_reason), 1'b1, 1'b1, 2);

      // Sweep all control settings over window, alias and ISA patterns.
      for (int cfg = 0; cfg < 8; cfg++) begin
         set_ctl(cfg[0], cfg[1], cfg[2]);
         for (int u = 0; u < 5; u++)
            for (int low = 0; low < 1024; low++)
               do_req(1'b1, (longint'(ups[u]) << 10) | longint'(low));
         for (int m = 0; m < 8; m++) begin
            do_req(1'b0, mems[m]);
            do_req(1'b1, mems[m]);
         end
         do_req(1'b1, 'h100003B0);
         do_req(1'b1, 'hFFFFFFDF);
      end

      @(negedge clk);
      req_valid = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule